// File: doc/BRIEF.md
# Snooping MESI Cache Line Controller

This block keeps the coherence state of a small group of cache lines for one processor on a shared snooping bus. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. The processor side issues read or write requests with a line index. Hits return at once. Misses and upgrades go to the bus as one of three transaction kinds, and the processor is stalled until the bus completes the transaction. The bus side presents transactions that other agents have completed. The block answers each one with a "we hold a copy" flag and a write-back request, and moves the line to its new state.

Data storage, tag compare, replacement and arbitration are outside the block. A read miss samples a shared flag when it completes. A clean line that nobody else holds is installed Exclusive, so a later local write upgrades silently with no bus traffic.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req_o` is low and `cpu_ready_o` is low.
- R2: A read to a line in Shared, Exclusive or Modified raises `cpu_ready_o` in the same cycle, raises no bus request and leaves the state as it was.
- R3: A read to an Invalid line raises `bus_req_o` in the next cycle with command 1 (read). When `bus_done_i` arrives, the line becomes Shared if `bus_shared_i` is high and Exclusive otherwise, and `cpu_ready_o` is high in that same cycle.
- R4: A write to an Exclusive line raises `cpu_ready_o` in the same cycle with no bus request, and the line becomes Modified.
- R5: A write to a Shared line requests command 3 (invalidate). A write to an Invalid line requests command 2 (read-exclusive). Either way the line is Modified once `bus_done_i` arrives.
- R6: A snooped read (`snoop_inv_i` low) to a Modified line raises `snoop_wb_o` in that cycle and leaves the line Shared. An Exclusive line becomes Shared without a write-back.
- R7: A snooped invalidate (`snoop_inv_i` high) makes any line Invalid, and raises `snoop_wb_o` if the line was Modified.
- R8: `snoop_shared_o` is high exactly when a snoop is presented and the addressed line is not Invalid. Both snoop outputs are low when there is no snoop.
- R9: When a snoop and a local request address the same line in one cycle, the snoop is applied first and the local request is decided on the resulting state.
- R10: While a bus request is outstanding, `cpu_ready_o` stays low until `bus_done_i`, and command and index stay stable.
- R11: Reads and writes that hit a Modified line leave it Modified with no bus request.
- R12: For two controllers sharing a bus, no line is ever Modified or Exclusive in both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_idx_i | input | IDX_W | Line index of the request |
| cpu_ready_o | output | 1 | Request completes this cycle |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_cmd_o | output | 2 | 1 read, 2 read-exclusive, 3 invalidate, 0 none |
| bus_idx_o | output | IDX_W | Line index of the bus transaction |
| bus_done_i | input | 1 | Own bus transaction completes this cycle |
| bus_shared_i | input | 1 | Another cache holds the line (sampled with done) |
| snoop_valid_i | input | 1 | Another agent's transaction is presented |
| snoop_inv_i | input | 1 | 1 = intent to write, 0 = read |
| snoop_idx_i | input | IDX_W | Line index of the snooped transaction |
| snoop_shared_o | output | 1 | This cache holds the snooped line |
| snoop_wb_o | output | 1 | Snooped line was Modified and must be written back |

## Verification
The assertions assume the following about the inputs. `bus_done_i` pulses only while this controller has a bus request outstanding. A processor request keeps its index and direction until `cpu_ready_o`. Snoops never coincide with the controller's own completion. The bench meets these assumptions with an arbiter model that grants one requester at a time and completes it after a random delay. The completion of one controller's transaction is broadcast as the snoop to the other. Processor requests are held until they complete, and some new requests are deliberately aimed at a line that is being snooped in the same cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_UPG = 2'd3} bus_cmd_t;

  function automatic mesi_t snoop_next(mesi_t cur, logic inv);
    if (inv || cur == ST_I) return ST_I;
    return ST_S;
  endfunction
endpackage

// File: rtl/mesi_line_slot.sv
module mesi_line_slot
  import mesi_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  snoop_hit_i,
  input  logic  snoop_inv_i,
  input  logic  upd_en_i,
  input  mesi_t upd_state_i,
  output mesi_t state_o,
  output mesi_t post_o
);
  mesi_t state_q;

  // snoop result, visible to the local request in the same cycle
  always_comb begin
    post_o = state_q;
    if (snoop_hit_i) post_o = snoop_next(state_q, snoop_inv_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= ST_I;
    else if (upd_en_i) state_q <= upd_state_i;
    else               state_q <= post_o;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  mesi_t            line_post_i,
  input  logic             bus_done_i,
  input  logic             bus_shared_i,
  output logic             ready_o,
  output logic             upd_en_o,
  output logic [IDX_W-1:0] upd_idx_o,
  output mesi_t            upd_state_o,
  output logic             bus_req_o,
  output bus_cmd_t         bus_cmd_o,
  output logic [IDX_W-1:0] bus_idx_o
);
  typedef enum logic {FSM_IDLE, FSM_WAIT} fsm_t;

  fsm_t             fsm_q, fsm_d;
  bus_cmd_t         cmd_q, cmd_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    fsm_d       = fsm_q;
    cmd_d       = cmd_q;
    idx_d       = idx_q;
    ready_o     = 1'b0;
    upd_en_o    = 1'b0;
    upd_idx_o   = idx_i;
    upd_state_o = ST_M;
    unique case (fsm_q)
      FSM_IDLE: begin
        if (req_i) begin
          if (!we_i && line_post_i != ST_I) begin
            ready_o = 1'b1;
          end else if (we_i && line_post_i == ST_M) begin
            ready_o = 1'b1;
          end else if (we_i && line_post_i == ST_E) begin
            ready_o  = 1'b1;   // silent upgrade
            upd_en_o = 1'b1;
          end else begin
            fsm_d = FSM_WAIT;
            idx_d = idx_i;
            if (!we_i)                   cmd_d = CMD_RD;
            else if (line_post_i == ST_S) cmd_d = CMD_UPG;
            else                          cmd_d = CMD_RDX;
          end
        end
      end
      FSM_WAIT: begin
        if (bus_done_i) begin
          ready_o     = 1'b1;
          upd_en_o    = 1'b1;
          upd_idx_o   = idx_q;
          upd_state_o = (cmd_q == CMD_RD) ? (bus_shared_i ? ST_S : ST_E) : ST_M;
          fsm_d       = FSM_IDLE;
        end
      end
      default: fsm_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q <= FSM_IDLE;
      cmd_q <= CMD_NONE;
      idx_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      cmd_q <= cmd_d;
      idx_q <= idx_d;
    end
  end

  assign bus_req_o = (fsm_q == FSM_WAIT);
  assign bus_cmd_o = (fsm_q == FSM_WAIT) ? cmd_q : CMD_NONE;
  assign bus_idx_o = idx_q;
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter  int unsigned NUM_LINES = 4,
  localparam int unsigned IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  output logic             cpu_ready_o,
  output logic             bus_req_o,
  output logic [1:0]       bus_cmd_o,
  output logic [IDX_W-1:0] bus_idx_o,
  input  logic             bus_done_i,
  input  logic             bus_shared_i,
  input  logic             snoop_valid_i,
  input  logic             snoop_inv_i,
  input  logic [IDX_W-1:0] snoop_idx_i,
  output logic             snoop_shared_o,
  output logic             snoop_wb_o
);
  mesi_t            line_q    [NUM_LINES];
  mesi_t            line_post [NUM_LINES];
  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;
  mesi_t            upd_state;
  bus_cmd_t         cmd;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    mesi_line_slot u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .snoop_hit_i (snoop_valid_i && snoop_idx_i == IDX_W'(g)),
      .snoop_inv_i (snoop_inv_i),
      .upd_en_i    (upd_en && upd_idx == IDX_W'(g)),
      .upd_state_i (upd_state),
      .state_o     (line_q[g]),
      .post_o      (line_post[g])
    );
  end

  mesi_req_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cpu_req_i),
    .we_i         (cpu_we_i),
    .idx_i        (cpu_idx_i),
    .line_post_i  (line_post[cpu_idx_i]),
    .bus_done_i   (bus_done_i),
    .bus_shared_i (bus_shared_i),
    .ready_o      (cpu_ready_o),
    .upd_en_o     (upd_en),
    .upd_idx_o    (upd_idx),
    .upd_state_o  (upd_state),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (cmd),
    .bus_idx_o    (bus_idx_o)
  );

  assign bus_cmd_o      = cmd;
  assign snoop_shared_o = snoop_valid_i && line_q[snoop_idx_i] != ST_I;
  assign snoop_wb_o     = snoop_valid_i && line_q[snoop_idx_i] == ST_M;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int unsigned IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_ready_o,
  input logic             bus_req_o,
  input logic [1:0]       bus_cmd_o,
  input logic [IDX_W-1:0] bus_idx_o,
  input logic             bus_done_i,
  input logic             snoop_valid_i,
  input logic             snoop_shared_o,
  input logic             snoop_wb_o
);
  // R10
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_cmd_o) && $stable(bus_idx_o));

  // R10
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |-> !cpu_ready_o);

  // R3
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_done_i |-> cpu_ready_o);

  // R3
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_done_i |=> !bus_req_o);

  // R5
  cmd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_cmd_o != 2'd0);

  // R8
  idle_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snoop_valid_i |-> !snoop_shared_o && !snoop_wb_o);

  // R2
  hit_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && !bus_req_o |=> !bus_req_o);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_ready_o    (cpu_ready_o),
  .bus_req_o      (bus_req_o),
  .bus_cmd_o      (bus_cmd_o),
  .bus_idx_o      (bus_idx_o),
  .bus_done_i     (bus_done_i),
  .snoop_valid_i  (snoop_valid_i),
  .snoop_shared_o (snoop_shared_o),
  .snoop_wb_o     (snoop_wb_o)
);

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb;
  localparam int SI = 0, SS = 1, SE = 2, SM = 3;
  localparam int RD = 1, RDX = 2, UPG = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_req, cpu_we, rdy, breq, bdone, bshared, snv, sninv, snsh, snwb;
  logic [1:0] cpu_idx [2];
  logic [1:0] bidx    [2];
  logic [1:0] snidx   [2];
  logic [1:0] bcmd    [2];

  int st [2][4];
  bit req_m [2];
  bit we_m  [2];
  bit pend  [2];
  int ridx  [2];
  int pcmd  [2];
  int pidx  [2];
  bit busy, prio, rnd_en;
  int own, cnt, race;
  int errors, checks;

  always #10 clk = ~clk;

  mesi_line_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req[0]), .cpu_we_i(cpu_we[0]), .cpu_idx_i(cpu_idx[0]), .cpu_ready_o(rdy[0]),
    .bus_req_o(breq[0]), .bus_cmd_o(bcmd[0]), .bus_idx_o(bidx[0]),
    .bus_done_i(bdone[0]), .bus_shared_i(bshared[0]),
    .snoop_valid_i(snv[0]), .snoop_inv_i(sninv[0]), .snoop_idx_i(snidx[0]),
    .snoop_shared_o(snsh[0]), .snoop_wb_o(snwb[0]));

  mesi_line_ctrl u_peer (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req[1]), .cpu_we_i(cpu_we[1]), .cpu_idx_i(cpu_idx[1]), .cpu_ready_o(rdy[1]),
    .bus_req_o(breq[1]), .bus_cmd_o(bcmd[1]), .bus_idx_o(bidx[1]),
    .bus_done_i(bdone[1]), .bus_shared_i(bshared[1]),
    .snoop_valid_i(snv[1]), .snoop_inv_i(sninv[1]), .snoop_idx_i(snidx[1]),
    .snoop_shared_o(snsh[1]), .snoop_wb_o(snwb[1]));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int snoop_model(int s, bit inv);
    if (inv || s == SI) return SI;
    return SS;
  endfunction

  // one cycle: drive at negedge, check, advance the model
  task automatic step();
    bit dn [2];
    int post [2][4];
    bit hit [2];
    bit sv [2];
    bit si [2];
    int sx [2];
    if (!busy) begin
      for (int j = 0; j < 2; j++) begin
        int k = (int'(prio) + j) % 2;
        if (!busy && pend[k]) begin
          busy = 1'b1; own = k; cnt = $urandom_range(2, 0);
        end
      end
      prio = ~prio;
    end
    for (int k = 0; k < 2; k++) dn[k] = busy && own == k && cnt == 0;
    for (int k = 0; k < 2; k++) begin
      sv[k] = dn[1-k];
      si[k] = pcmd[1-k] != RD;
      sx[k] = pidx[1-k];
    end
    // R9 directed: local read aimed at the line being invalidated this cycle
    if (race >= 0 && dn[1] && !req_m[0] && !pend[0]) begin
      req_m[0] = 1'b1; we_m[0] = 1'b0; ridx[0] = race;
    end
    for (int k = 0; k < 2; k++) begin
      if (rnd_en && !req_m[k] && !pend[k] && $urandom_range(3, 0) != 0) begin
        req_m[k] = 1'b1;
        we_m[k]  = 1'($urandom_range(1, 0));
        ridx[k]  = (sv[k] && $urandom_range(1, 0) == 1) ? sx[k] : int'($urandom_range(3, 0));
      end
    end
    for (int k = 0; k < 2; k++) begin
      cpu_req[k] = req_m[k];
      cpu_we[k]  = we_m[k];
      cpu_idx[k] = 2'(ridx[k]);
      bdone[k]   = dn[k];
      bshared[k] = dn[k] && st[1-k][pidx[k]] != SI;
      snv[k]     = sv[k];
      sninv[k]   = si[k];
      snidx[k]   = 2'(sx[k]);
    end
    #1;
    for (int k = 0; k < 2; k++) begin
      int ps;
      string tg;
      if (sv[k]) begin
        check("R8 snoop_shared", int'(snsh[k]), int'(st[k][sx[k]] != SI));
        check(si[k] ? "R7 write-back on invalidate" : "R6 write-back on read", int'(snwb[k]), int'(st[k][sx[k]] == SM));
      end else begin
        check("R8 idle snoop_shared", int'(snsh[k]), 0);
        check("R8 idle write-back", int'(snwb[k]), 0);
      end
      for (int l = 0; l < 4; l++) post[k][l] = st[k][l];
      if (sv[k]) post[k][sx[k]] = snoop_model(st[k][sx[k]], si[k]);
      ps = post[k][ridx[k]];
      hit[k] = we_m[k] ? (ps == SM || ps == SE) : (ps != SI);
      if (pend[k]) begin
        check("R10 bus_req held", int'(breq[k]), 1);
        check(pcmd[k] == RD ? "R3 bus command" : "R5 bus command", int'(bcmd[k]), pcmd[k]);
        check("R10 bus index", int'(bidx[k]), pidx[k]);
        check("R10 ready on completion", int'(rdy[k]), int'(dn[k]));
      end else begin
        check("R2 no bus request when idle", int'(breq[k]), 0);
        if (sv[k] && req_m[k] && sx[k] == ridx[k]) tg = "R9 ready after same-cycle snoop";
        else if (!we_m[k]) tg = (ps == SI) ? "R3 read miss ready" : "R2 read hit ready";
        else if (ps == SE) tg = "R4 silent upgrade ready";
        else if (ps == SM) tg = "R11 modified hit ready";
        else tg = "R5 write miss ready";
        check(tg, int'(rdy[k]), int'(req_m[k] && hit[k]));
      end
    end
    for (int k = 0; k < 2; k++) begin
      for (int l = 0; l < 4; l++) st[k][l] = post[k][l];
      if (pend[k]) begin
        if (dn[k]) begin
          st[k][pidx[k]] = (pcmd[k] == RD) ? (bshared[k] ? SS : SE) : SM;
          pend[k] = 1'b0; req_m[k] = 1'b0;
        end
      end else if (req_m[k]) begin
        if (hit[k]) begin
          if (we_m[k]) st[k][ridx[k]] = SM;
          req_m[k] = 1'b0;
        end else begin
          pend[k] = 1'b1; pidx[k] = ridx[k];
          pcmd[k] = !we_m[k] ? RD : (post[k][ridx[k]] == SS ? UPG : RDX);
        end
      end
    end
    for (int l = 0; l < 4; l++)
      if ((st[0][l] == SM || st[0][l] == SE) && st[1][l] != SI)
        check("R12 single owner", st[1][l], SI);
    if (busy) begin
      if (cnt == 0) busy = 1'b0;
      else cnt--;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic op(int k, bit we, int idx);
    req_m[k] = 1'b1; we_m[k] = we; ridx[k] = idx;
    for (int n = 0; n < 40 && (req_m[k] || pend[k]); n++) step();
  endtask

  initial begin
    #(64'd4_000_000);
    errors++; checks++;
    $display("FAIL watchdog R10 act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd486));
    errors = 0; checks = 0; busy = 0; prio = 0; rnd_en = 0; own = 0; cnt = 0; race = -1;
    for (int k = 0; k < 2; k++) begin
      req_m[k] = 0; we_m[k] = 0; pend[k] = 0; ridx[k] = 0; pcmd[k] = RD; pidx[k] = 0;
      for (int l = 0; l < 4; l++) st[k][l] = SI;
      cpu_req[k] = 0; cpu_we[k] = 0; cpu_idx[k] = 0; bdone[k] = 0; bshared[k] = 0;
      snv[k] = 0; sninv[k] = 0; snidx[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    for (int k = 0; k < 2; k++) begin
      check("R1 reset bus_req", int'(breq[k]), 0);
      check("R1 reset ready", int'(rdy[k]), 0);
    end
    op(0, 1'b0, 0);   // R3 miss, no sharer -> Exclusive
    op(0, 1'b1, 0);   // R4 silent upgrade
    op(1, 1'b0, 0);   // R6 Modified snooped by read
    op(0, 1'b1, 0);   // R5 invalidate from Shared
    op(1, 1'b1, 0);   // R5 read-exclusive, R7 Modified invalidated
    op(0, 1'b0, 0);   // R3 shared fill
    op(1, 1'b0, 0);   // R2 read hit
    op(1, 1'b1, 1);
    op(1, 1'b1, 1);   // R11
    op(1, 1'b0, 1);   // R11
    op(0, 1'b0, 2);   // Exclusive in u_dut
    race = 2;
    op(1, 1'b1, 2);   // R9 u_dut read collides with invalidate
    race = -1;
    op(0, 1'b0, 3);
    for (int n = 0; n < 40 && (req_m[0] || pend[0]); n++) step();
    rnd_en = 1'b1;
    repeat (3000) step();
    rnd_en = 1'b0;
    for (int n = 0; n < 60 && (req_m[0] || pend[0] || req_m[1] || pend[1]); n++) step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule